// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Receiver

This block takes one line bit per qualified clock and turns it into a stream of payload octets. In its framed mode it finds the 0x7E delimiter, strips the zero that a sender inserts after five ones, and packs the remaining bits into octets, least significant bit first. It verifies the trailing frame check sequence (FCS). A run-time select chooses between a 16-bit CCITT check and a 32-bit check. It also watches for line aborts, for frames that do not end on an octet boundary, and for frames whose octet count falls outside a programmable window. Optionally it cuts oversize frames short.

Payload octets leave on `outValid` / `outData`, and the first octet of each frame is marked with `outSof`. The FCS octets are never forwarded. Every frame that produced at least one complete octet is closed by a single `outEof` cycle. In that cycle `outStatus` carries the error summary. A transparent mode bypasses all of the framing logic and hands on every eight received bits as one octet.

Top module: `hdlc_frame_rx`

## Requirements
- R1: A frame lies between two 0x7E flags. Flags that follow one another with no complete octet between them produce no output at all.
- R2: While a frame is open, a 0 bit received directly after five consecutive 1 bits is discarded, so payload octets containing runs of ones come out intact.
- R3: Octets are assembled least significant bit first. The last 2 octets (16-bit check) or the last 4 octets (32-bit check) of a frame are never forwarded. `outSof` is high only together with `outValid` on the first forwarded octet of a frame.
- R4: With `cfgFcs32`=0, the check uses polynomial x^16+x^12+x^5+1, preset all ones, reflected, with good residue 0xF0B8. A mismatch on an octet-aligned frame sets `outStatus` bit 0.
- R5: With `cfgFcs32`=1, the check uses the 32-bit Ethernet polynomial, preset all ones, reflected, with good residue 0xDEBB20E3. A mismatch on an aligned frame sets `outStatus` bit 0.
- R6: Seven or more consecutive 1s close an open frame at once. The end marker carries status 0x02 only, and everything up to the next flag is ignored.
- R7: If the number of bits between flags, after destuffing, is not a multiple of 8, `outStatus` bit 2 is set and bit 0 is left clear.
- R8: A frame whose octet count, FCS included, is below `cfgMinLen` sets `outStatus` bit 3.
- R9: With `cfgDropLong`=0, a frame whose octet count, FCS included, is above `cfgMaxLen` is delivered whole and sets `outStatus` bit 4.
- R10: With `cfgDropLong`=1, the octet that pushes the count above `cfgMaxLen` ends the frame. The end marker carries status 0x10 only, and no further octet is output until the next flag.
- R11: With `cfgTransparent`=1, every 8 received bits become one output octet unchanged, LSB first, with no flag, stuffing or check handling and no `outSof` or `outEof`.
- R12: The end marker lasts one cycle with `outValid` low, and `outStatus` is zero outside it. During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Received line bit |
| cfgTransparent | input | 1 | 1 = raw octet bypass |
| cfgFcs32 | input | 1 | 1 = 32-bit check, 0 = 16-bit check |
| cfgDropLong | input | 1 | 1 = end oversize frames early |
| cfgMinLen | input | 16 | Smallest legal octet count, FCS included |
| cfgMaxLen | input | 16 | Largest legal octet count, FCS included |
| outValid | output | 1 | Output octet strobe |
| outData | output | 8 | Output octet |
| outSof | output | 1 | First octet of a frame |
| outEof | output | 1 | End-of-frame marker |
| outStatus | output | 5 | bit0 check error, bit1 abort, bit2 not aligned, bit3 short, bit4 long |

## Verification
The assertions assume that the configuration inputs change only while the line is idle between frames. In particular, the check width and the mode select must never change while a frame is open. They also assume that a framed line carries a flag before any payload. Every scenario in the bench sets its configuration while `bitValid` is low, opens each frame with a flag, and leaves the mode only after the closing flag and a few idle cycles. Out-of-range stimulus, such as seven ones, stray zero bits or oversize payloads, is injected only inside a frame, where the requirements define the result.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int OCTET_W = 8;
  localparam int FCS_MAX = 4;
  localparam int CRC_W   = 32;
  localparam int STAT_W  = 5;
  localparam int ONES_W  = 3;

  localparam int ST_FCS   = 0;
  localparam int ST_ABORT = 1;
  localparam int ST_ALIGN = 2;
  localparam int ST_SHORT = 3;
  localparam int ST_LONG  = 4;

  localparam logic [CRC_W-1:0] POLY16  = 32'h0000_8408;
  localparam logic [CRC_W-1:0] POLY32  = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] PRESET  = 32'hFFFF_FFFF;
  localparam logic [15:0]      GOOD16  = 16'hF0B8;
  localparam logic [CRC_W-1:0] GOOD32  = 32'hDEBB_20E3;

  typedef struct packed {
    logic takeBits;
    logic clrFrame;
  } dpCtrl_t;

  typedef enum logic [0:0] {S_HUNT, S_OPEN} rxState_t;

  function automatic logic [CRC_W-1:0] crcOctet(input logic [CRC_W-1:0] cIn,
                                                input logic [OCTET_W-1:0] d,
                                                input logic wide);
    logic [CRC_W-1:0] c;
    logic fb;
    c = wide ? cIn : {16'h0000, cIn[15:0]};
    for (int i = 0; i < OCTET_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ (wide ? POLY32 : POLY16);
    end
    return c;
  endfunction
endpackage

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
#(
  parameter int WIN_W = 2*OCTET_W-1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic               cfgTransparent,
  input  logic               cfgFcs32,
  input  dpCtrl_t            ctl,
  output logic               evFlag,
  output logic               evAbort,
  output logic               octValid,
  output logic               fwdValid,
  output logic [OCTET_W-1:0] fwdData,
  output logic               tailAligned,
  output logic               crcGood,
  output logic               trnValid,
  output logic [OCTET_W-1:0] trnData
);
  localparam int HELD_W = $clog2(WIN_W+1);
  localparam int OCC_W  = $clog2(FCS_MAX+1);
  localparam int TC_W   = $clog2(OCTET_W);
  localparam logic [HELD_W-1:0] HELD_FULL = HELD_W'(WIN_W-1);
  localparam logic [HELD_W-1:0] HELD_TAIL = HELD_W'(OCTET_W-1);
  localparam logic [ONES_W-1:0] ONES_MAX  = '1;

  logic [ONES_W-1:0]  onesRun;
  logic [WIN_W-1:0]   win;
  logic [HELD_W-1:0]  held;
  logic [FCS_MAX-1:0][OCTET_W-1:0] dly;
  logic [OCC_W-1:0]   occ;
  logic [CRC_W-1:0]   crc;
  logic [TC_W-1:0]    tCnt;
  logic [OCTET_W-1:0] tSh;

  logic hdlcBit, stuffed, dataBit;
  logic [WIN_W-1:0] winNext;
  logic [OCTET_W-1:0] octData;
  logic [OCC_W-1:0] fcsBytes;

  // bit classification from the run of ones seen so far
  assign hdlcBit  = bitValid && !cfgTransparent;
  assign evFlag   = hdlcBit && !bitIn && (onesRun == ONES_W'(6));
  assign evAbort  = hdlcBit &&  bitIn && (onesRun >= ONES_W'(6));
  assign stuffed  = hdlcBit && !bitIn && (onesRun == ONES_W'(5));
  assign dataBit  = hdlcBit && ctl.takeBits && !evFlag && !evAbort && !stuffed;

  // window keeps the 7 newest bits back until a flag can be ruled out
  assign winNext  = {bitIn, win[WIN_W-1:1]};
  assign octValid = dataBit && (held == HELD_FULL);
  assign octData  = winNext[OCTET_W-1:0];

  assign fcsBytes = cfgFcs32 ? OCC_W'(FCS_MAX) : OCC_W'(FCS_MAX/2);
  assign fwdValid = octValid && (occ == fcsBytes);
  assign fwdData  = cfgFcs32 ? dly[FCS_MAX-1] : dly[FCS_MAX/2-1];

  assign tailAligned = (held == HELD_TAIL);
  assign crcGood     = cfgFcs32 ? (crc == GOOD32) : (crc[15:0] == GOOD16);

  assign trnValid = cfgTransparent && bitValid && (tCnt == TC_W'(OCTET_W-1));
  assign trnData  = {bitIn, tSh[OCTET_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onesRun <= '0;
      win     <= '0;
      held    <= '0;
      dly     <= '0;
      occ     <= '0;
      crc     <= PRESET;
      tCnt    <= '0;
      tSh     <= '0;
    end else begin
      if (cfgTransparent) onesRun <= '0;
      else if (hdlcBit) onesRun <= !bitIn ? '0 : (onesRun == ONES_MAX ? ONES_MAX : onesRun + 1'b1);

      if (dataBit) win <= winNext;

      if (ctl.clrFrame) begin
        held <= '0;
        occ  <= '0;
        crc  <= PRESET;
      end else if (dataBit) begin
        held <= octValid ? HELD_TAIL : held + 1'b1;
        if (octValid) begin
          dly <= {dly[FCS_MAX-2:0], octData};
          occ <= (occ == fcsBytes) ? occ : occ + 1'b1;
          crc <= crcOctet(crc, octData, cfgFcs32);
        end
      end

      if (!cfgTransparent) begin
        tCnt <= '0;
      end else if (bitValid) begin
        tSh  <= trnData;
        tCnt <= tCnt + 1'b1;
      end
    end
  end

  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    held <= HELD_FULL);
  assert_fcs_hold_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(FCS_MAX));
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgTransparent,
  input  logic               cfgDropLong,
  input  logic [LEN_W-1:0]   cfgMinLen,
  input  logic [LEN_W-1:0]   cfgMaxLen,
  input  logic               evFlag,
  input  logic               evAbort,
  input  logic               octValid,
  input  logic               fwdValid,
  input  logic [OCTET_W-1:0] fwdData,
  input  logic               tailAligned,
  input  logic               crcGood,
  input  logic               trnValid,
  input  logic [OCTET_W-1:0] trnData,
  output dpCtrl_t            ctl,
  output logic               outValid,
  output logic [OCTET_W-1:0] outData,
  output logic               outSof,
  output logic               outEof,
  output logic [STAT_W-1:0]  outStatus
);
  rxState_t          state;
  logic [LEN_W-1:0]  octCount, cntNext;
  logic              sofDone, overLong, frameLive;
  logic [STAT_W-1:0] closeStat;

  assign cntNext   = (&octCount) ? octCount : octCount + 1'b1;
  assign overLong  = octValid && cfgDropLong && (cntNext > cfgMaxLen);
  assign frameLive = (state == S_OPEN) && (octCount != '0);

  always_comb begin
    ctl.takeBits = (state == S_OPEN) && !cfgTransparent;
    ctl.clrFrame = evFlag || evAbort || overLong;
    closeStat = '0;
    closeStat[ST_FCS]   = tailAligned && !crcGood;
    closeStat[ST_ALIGN] = !tailAligned;
    closeStat[ST_SHORT] = octCount < cfgMinLen;
    closeStat[ST_LONG]  = octCount > cfgMaxLen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_HUNT;
      octCount  <= '0;
      sofDone   <= 1'b0;
      outValid  <= 1'b0;
      outData   <= '0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outStatus <= '0;
    end else begin
      outValid  <= 1'b0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outStatus <= '0;
      if (cfgTransparent) begin
        state    <= S_HUNT;
        octCount <= '0;
        sofDone  <= 1'b0;
        if (trnValid) begin
          outValid <= 1'b1;
          outData  <= trnData;
        end
      end else if (evAbort) begin
        if (frameLive) begin
          outEof              <= 1'b1;
          outStatus[ST_ABORT] <= 1'b1;
        end
        state    <= S_HUNT;
        octCount <= '0;
        sofDone  <= 1'b0;
      end else if (evFlag) begin
        if (frameLive) begin
          outEof    <= 1'b1;
          outStatus <= closeStat;
        end
        state    <= S_OPEN;
        octCount <= '0;
        sofDone  <= 1'b0;
      end else if (overLong) begin
        outEof             <= 1'b1;
        outStatus[ST_LONG] <= 1'b1;
        state    <= S_HUNT;
        octCount <= '0;
        sofDone  <= 1'b0;
      end else if (octValid) begin
        octCount <= cntNext;
        if (fwdValid) begin
          outValid <= 1'b1;
          outData  <= fwdData;
          outSof   <= !sofDone;
          sofDone  <= 1'b1;
        end
      end
    end
  end

  assert_sof_with_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outSof |-> outValid);
  assert_abort_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outEof && outStatus[ST_ABORT]) |-> ($countones(outStatus) == 1));
  assert_align_masks_fcs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outEof && outStatus[ST_ALIGN]) |-> !outStatus[ST_FCS]);
  assert_bypass_no_marks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfgTransparent) |-> (!outSof && !outEof));
  assert_marker_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outEof |-> !outValid);
  assert_status_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !outEof |-> (outStatus == '0));
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic               cfgTransparent,
  input  logic               cfgFcs32,
  input  logic               cfgDropLong,
  input  logic [LEN_W-1:0]   cfgMinLen,
  input  logic [LEN_W-1:0]   cfgMaxLen,
  output logic               outValid,
  output logic [OCTET_W-1:0] outData,
  output logic               outSof,
  output logic               outEof,
  output logic [STAT_W-1:0]  outStatus
);
  dpCtrl_t            ctl;
  logic               evFlag, evAbort, octValid, fwdValid, tailAligned, crcGood, trnValid;
  logic [OCTET_W-1:0] fwdData, trnData;

  hdlc_rx_datapath u_datapath (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .cfgTransparent(cfgTransparent), .cfgFcs32(cfgFcs32), .ctl(ctl),
    .evFlag(evFlag), .evAbort(evAbort), .octValid(octValid),
    .fwdValid(fwdValid), .fwdData(fwdData), .tailAligned(tailAligned),
    .crcGood(crcGood), .trnValid(trnValid), .trnData(trnData)
  );

  hdlc_rx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgTransparent(cfgTransparent),
    .cfgDropLong(cfgDropLong), .cfgMinLen(cfgMinLen), .cfgMaxLen(cfgMaxLen),
    .evFlag(evFlag), .evAbort(evAbort), .octValid(octValid),
    .fwdValid(fwdValid), .fwdData(fwdData), .tailAligned(tailAligned),
    .crcGood(crcGood), .trnValid(trnValid), .trnData(trnData), .ctl(ctl),
    .outValid(outValid), .outData(outData), .outSof(outSof),
    .outEof(outEof), .outStatus(outStatus)
  );
endmodule

// File: tb/hdlc_frame_rx_bench.sv
module hdlc_frame_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitValid = 1'b0, bitIn = 1'b0;
  logic cfgTransparent = 1'b0, cfgFcs32 = 1'b0, cfgDropLong = 1'b0;
  logic [15:0] cfgMinLen = 16'd4, cfgMaxLen = 16'd40;
  logic outValid, outSof, outEof;
  logic [7:0] outData;
  logic [4:0] outStatus;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_frame_rx u_hdlc_frame_rx (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .cfgTransparent(cfgTransparent), .cfgFcs32(cfgFcs32), .cfgDropLong(cfgDropLong),
    .cfgMinLen(cfgMinLen), .cfgMaxLen(cfgMaxLen), .outValid(outValid),
    .outData(outData), .outSof(outSof), .outEof(outEof), .outStatus(outStatus)
  );

  int nChecks = 0, nErr = 0, txOnes = 0, rxN = 0, eofN = 0;
  bit finished = 0;
  logic [7:0] txBuf [64];
  logic [7:0] rxData [256];
  logic       rxSofA [256];
  logic [4:0] eofStat [16];

  always @(negedge clk) begin
    if (rst_n) begin
      if (outValid) begin
        if (rxN < 256) begin rxData[rxN] = outData; rxSofA[rxN] = outSof; end
        rxN++;
      end
      if (outEof) begin
        if (eofN < 16) eofStat[eofN] = outStatus;
        eofN++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearCapture();
    rxN = 0; eofN = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitIn = b; bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendOctet(input logic [7:0] v, input bit stuff);
    for (int i = 0; i < 8; i++) begin
      sendBit(v[i]);
      if (stuff) begin
        if (v[i]) txOnes++; else txOnes = 0;
        if (txOnes == 5) begin sendBit(1'b0); txOnes = 0; end
      end
    end
  endtask

  task automatic sendFlag();
    sendOctet(8'h7E, 1'b0);
    txOnes = 0;
  endtask

  task automatic fillBuf(input int n, input int seed);
    for (int i = 0; i < n; i++)
      txBuf[i] = (i % 3 == 0) ? 8'hFF : 8'(seed + i * 37);
  endtask

  function automatic logic [31:0] benchFcs(input int n, input bit wide);
    logic [31:0] c;
    logic fb;
    c = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ txBuf[i][j];
        c = c >> 1;
        if (fb) c = c ^ (wide ? 32'hEDB88320 : 32'h00008408);
      end
    return ~c;
  endfunction

  task automatic sendFrame(input int n, input bit wide, input bit corrupt, input int extraZeros);
    logic [31:0] fcs;
    logic [7:0] b;
    fcs = benchFcs(n, wide);
    sendFlag();
    for (int i = 0; i < n; i++) sendOctet(txBuf[i], 1'b1);
    for (int k = 0; k < (wide ? 4 : 2); k++) begin
      b = fcs[8*k +: 8];
      if (corrupt && k == 0) b = b ^ 8'h01;
      sendOctet(b, 1'b1);
    end
    for (int k = 0; k < extraZeros; k++) begin sendBit(1'b0); txOnes = 0; end
    sendFlag();
    idle(4);
  endtask

  task automatic expectData(input int n, input string req);
    check(rxN == n, req, "octet count", rxN, n);
    for (int i = 0; i < n && i < rxN; i++) begin
      check(rxData[i] == txBuf[i], req, $sformatf("octet %0d", i), rxData[i], txBuf[i]);
      check(rxSofA[i] == (i == 0), req, $sformatf("sof %0d", i), rxSofA[i], (i == 0));
    end
  endtask

  task automatic expectEof(input logic [4:0] stat, input string req);
    check(eofN == 1, req, "end markers", eofN, 1);
    if (eofN > 0) check(eofStat[0] == stat, req, "status", eofStat[0], stat);
  endtask

  task automatic t_crc16(); // R1 R2 R3 R4
    cfgFcs32 = 0; cfgMinLen = 4; cfgMaxLen = 40; cfgDropLong = 0;
    clearCapture(); fillBuf(5, 8'h21); sendFrame(5, 0, 0, 0);
    expectData(5, "R2_R3_R4"); expectEof(5'h00, "R4");
    clearCapture(); fillBuf(4, 8'h5A); sendFrame(4, 0, 1, 0);
    expectData(4, "R3"); expectEof(5'h01, "R4");
  endtask

  task automatic t_crc32(); // R5
    cfgFcs32 = 1;
    clearCapture(); fillBuf(6, 8'h13); sendFrame(6, 1, 0, 0);
    expectData(6, "R5"); expectEof(5'h00, "R5");
    clearCapture(); fillBuf(6, 8'h77); sendFrame(6, 1, 1, 0);
    expectData(6, "R5"); expectEof(5'h01, "R5");
    cfgFcs32 = 0;
  endtask

  task automatic t_flagsOnly(); // R1
    clearCapture();
    repeat (4) sendFlag();
    idle(4);
    check(rxN == 0, "R1", "octets on idle flags", rxN, 0);
    check(eofN == 0, "R1", "markers on idle flags", eofN, 0);
  endtask

  task automatic t_abort(); // R6
    clearCapture();
    sendFlag();
    sendOctet(8'h11, 1); sendOctet(8'h22, 1); sendOctet(8'h33, 1); sendOctet(8'h44, 1);
    repeat (8) sendBit(1'b1);
    sendOctet(8'h55, 0); sendOctet(8'h66, 0);
    idle(4);
    check(rxN == 1, "R6", "octets before abort", rxN, 1);
    if (rxN > 0) check(rxData[0] == 8'h11, "R6", "octet 0", rxData[0], 8'h11);
    expectEof(5'h02, "R6");
    clearCapture(); fillBuf(3, 8'h09); sendFrame(3, 0, 0, 0);
    expectData(3, "R6"); expectEof(5'h00, "R6");
  endtask

  task automatic t_nonAligned(); // R7
    clearCapture(); fillBuf(3, 8'h40); sendFrame(3, 0, 0, 3);
    expectData(3, "R7"); expectEof(5'h04, "R7");
  endtask

  task automatic t_short(); // R8
    cfgMinLen = 8;
    clearCapture(); fillBuf(2, 8'h31); sendFrame(2, 0, 0, 0);
    expectData(2, "R8"); expectEof(5'h08, "R8");
    cfgMinLen = 4;
  endtask

  task automatic t_longKeep(); // R9
    cfgMaxLen = 6; cfgDropLong = 0;
    clearCapture(); fillBuf(8, 8'h62); sendFrame(8, 0, 0, 0);
    expectData(8, "R9"); expectEof(5'h10, "R9");
  endtask

  task automatic t_longDrop(); // R10
    cfgMaxLen = 6; cfgDropLong = 1;
    clearCapture(); fillBuf(8, 8'h18); sendFrame(8, 0, 0, 0);
    expectData(4, "R10"); expectEof(5'h10, "R10");
    cfgMaxLen = 40; cfgDropLong = 0;
  endtask

  task automatic t_transparent(); // R11
    logic [7:0] raw [4];
    raw[0] = 8'h7E; raw[1] = 8'hFF; raw[2] = 8'h00; raw[3] = 8'hA5;
    cfgTransparent = 1; idle(2);
    clearCapture();
    for (int i = 0; i < 4; i++) sendOctet(raw[i], 0);
    idle(4);
    check(rxN == 4, "R11", "raw octet count", rxN, 4);
    for (int i = 0; i < 4 && i < rxN; i++) begin
      check(rxData[i] == raw[i], "R11", $sformatf("raw %0d", i), rxData[i], raw[i]);
      check(rxSofA[i] == 1'b0, "R11", "sof in bypass", rxSofA[i], 0);
    end
    check(eofN == 0, "R11", "markers in bypass", eofN, 0);
    cfgTransparent = 0; idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({outValid, outSof, outEof} == 3'b000, "R12", "reset strobes", {outValid, outSof, outEof}, 0);
    check(outStatus == 5'h00, "R12", "reset status", outStatus, 0);
    rst_n = 1'b1;
    idle(2);
    t_flagsOnly();
    t_crc16();
    t_crc32();
    t_abort();
    t_nonAligned();
    t_short();
    t_longKeep();
    t_longDrop();
    t_transparent();
    clearCapture(); fillBuf(5, 8'h0F); sendFrame(5, 0, 0, 0);
    expectData(5, "R11"); expectEof(5'h00, "R11");
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nErr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end
endmodule